// File: doc/BRIEF.md
# APB Access-Control Bridge

This bridge sits between one upstream requester port and a downstream APB slave segment. Every request arrives tagged with a 3-bit hardware identity of the issuing master, a privilege flag, a secure flag and an instruction/data flag. The bridge decides for each request whether it may proceed. A permitted request is replayed on the APB side as a two-phase transfer. A refused request is answered locally with an error and never appears on the APB bus.

The decision works on sixteen transaction classes: eight identities, each split into read and write. A 3-bit protection field on the bus could only tell eight kinds of transfer apart. A 16-bit permission mask has one bit per class and applies only to a single protected address window. That window holds, for example, the thermal-shutdown limits of a power-management slave. Addresses outside the window pass for every requester. Two rules hold inside the window:
- A write from a requester without privilege is refused, whatever the mask says.
- The mask is loaded through a configuration port. A sticky lock bit freezes the mask until reset.

The upstream requester holds `req_valid` and its fields steady until it sees `rsp_done`. It must drop `req_valid` or present a new request in the cycle after completion.

Top module: `apb_guard_bridge`

## Requirements
- R1: After reset `psel`, `penable` and `rsp_done` are low, the lock is clear, and the permission mask is all zeros, so every access inside the protected window is refused.
- R2: A request whose address lies outside the window `[WIN_LO, WIN_HI]` (inclusive) is forwarded for every identity, privilege and direction.
- R3: A request inside the window is forwarded only if mask bit `2*id + write` is set, where `write` is 1 for a write. Bit 2*id is the read class of identity `id` and bit 2*id+1 is its write class.
- R4: A write inside the window with `req_priv` low is refused, even when its mask bit is set.
- R5: A refused request completes in the cycle it is presented in the idle state: `rsp_done` and `rsp_err` are high and `rsp_rdata` is zero. `psel` stays low throughout.
- R6: For a forwarded request, `psel` is high with `penable` low in the cycle after acceptance. `penable` rises in the following cycle. Both stay high until the cycle in which `pready` is high. `paddr`, `pwrite`, `pwdata` and `pprot` stay stable for the whole transfer.
- R7: `pprot` during a transfer is `{req_instr, ~req_sec, req_priv}`. Bit 0 is privileged, bit 1 is non-secure and bit 2 is instruction fetch.
- R8: A forwarded request completes in the ACCESS cycle in which `pready` is high. In that cycle `rsp_done` is high, `rsp_err` equals `pslverr` and `rsp_rdata` equals `prdata`.
- R9: `cfg_we` loads `cfg_mask` into the mask only while the lock is clear. `cfg_lock` sets the lock, which then stays set until reset. A write presented in the same cycle as the lock request still takes effect. Later writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_id | input | ID_W | Hardware identity of the requester |
| req_priv | input | 1 | Privileged requester |
| req_sec | input | 1 | Secure requester |
| req_instr | input | 1 | Instruction fetch (1) or data (0) |
| req_write | input | 1 | Write (1) or read (0) |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | Request completed this cycle |
| rsp_err | output | 1 | Completion carries an error |
| rsp_rdata | output | DATA_W | Read data, zero on refusal |
| cfg_we | input | 1 | Load permission mask |
| cfg_mask | input | 2**(ID_W+1) | New permission mask |
| cfg_lock | input | 1 | Set the sticky lock |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| pprot | output | 3 | APB protection attributes |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB slave ready |
| pslverr | input | 1 | APB slave error |

## Verification
The mask update and the setting of the lock can fall in the same clock cycle. The bench provokes this after a fresh reset by raising `cfg_we` and `cfg_lock` together. It then attempts a second mask write, probes both classes of one identity inside the window, and judges from the forward/refuse outcome at the ports that the first mask was kept and the second ignored. The sweep of classes, privilege, window edges and slave wait states is repeated under several mask patterns. The expected decision, latency, protection bits and response data are all computed from R2 to R8.

// File: rtl/apb_guard_bridge.sv
module apb_guard_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int ID_W = 3,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h40,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h4F,
  localparam int MASK_W = 2 ** (ID_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_priv,
  input  logic              req_sec,
  input  logic              req_instr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_we,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_lock,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  output logic [2:0]        pprot,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACCESS} state_t;
  state_t st;

  logic [MASK_W-1:0] mask_q;
  logic              lock_q;

  logic            in_win, user_wr, allow, take, deny, fin;
  logic [ID_W:0]   cls;

  assign in_win  = (req_addr >= WIN_LO) && (req_addr <= WIN_HI);
  assign cls     = {req_id, req_write};
  assign user_wr = req_write && !req_priv;
  assign allow   = !in_win || (mask_q[cls] && !user_wr);
  assign take    = (st == S_IDLE) && req_valid;
  assign deny    = take && !allow;
  assign fin     = (st == S_ACCESS) && pready;

  assign rsp_done  = deny || fin;
  assign rsp_err   = deny || (fin && pslverr);
  assign rsp_rdata = fin ? prdata : '0;

  assign psel    = (st != S_IDLE);
  assign penable = (st == S_ACCESS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cfg_we && !lock_q) mask_q <= cfg_mask;
      if (cfg_lock) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pwrite <= 1'b0;
      paddr  <= '0;
      pwdata <= '0;
      pprot  <= '0;
    end else begin
      case (st)
        S_IDLE: if (take && allow) begin
          st     <= S_SETUP;
          pwrite <= req_write;
          paddr  <= req_addr;
          pwdata <= req_wdata;
          pprot  <= {req_instr, !req_sec, req_priv};
        end
        S_SETUP:  st <= S_ACCESS;
        S_ACCESS: if (pready) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  a_r6_enable_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel);

  a_r6_setup_then_access: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  a_r6_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr)
      && $stable(pwrite) && $stable(pwdata) && $stable(pprot)));

  a_r5_refused_never_selects: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> !psel);

  a_r4_user_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_win && user_wr) |=> !psel);

  a_r8_done_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && psel) |-> (penable && pready));

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mask_q));

endmodule

// File: tb/test_apb_guard_bridge.sv
module test_apb_guard_bridge;
  localparam int AW = 8, DW = 16, IW = 3, MW = 16;
  localparam logic [AW-1:0] LO = 8'h40, HI = 8'h4F;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_priv = 0, req_sec = 0, req_instr = 0, req_write = 0;
  logic [IW-1:0] req_id = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic cfg_we = 0, cfg_lock = 0;
  logic [MW-1:0] cfg_mask = '0;
  logic psel, penable, pwrite, pready, pslverr;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata;
  logic [2:0] pprot;

  int checks = 0, errors = 0, waitn = 0;
  logic [3:0] acnt;

  always #5 clk = ~clk;

  apb_guard_bridge #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .WIN_LO(LO), .WIN_HI(HI)) i_apb_guard_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_priv(req_priv),
    .req_sec(req_sec), .req_instr(req_instr), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_lock(cfg_lock), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot), .prdata(prdata),
    .pready(pready), .pslverr(pslverr));

  always_ff @(posedge clk)
    if (!(psel && penable)) acnt <= '0;
    else if (!pready) acnt <= acnt + 4'd1;

  assign pready  = psel && penable && (int'(acnt) >= waitn);
  assign pslverr = psel && penable && (paddr[3:0] == 4'hF);
  assign prdata  = {paddr, ~paddr};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load_mask(input logic [MW-1:0] m, input bit lk);
    @(negedge clk);
    cfg_we = 1; cfg_mask = m; cfg_lock = lk;
    @(negedge clk);
    cfg_we = 0; cfg_lock = 0;
  endtask

  task automatic txn(input logic [IW-1:0] id, input bit w, input bit pv, input bit sc,
                     input bit ins, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input bit exp_allow, input string tag, input int wt);
    int cyc = 0, done_cyc = -1;
    bit seq_ok = 1, attr_ok = 1, err_got = 0;
    logic [DW-1:0] rd_got = '0;
    logic [2:0] pp_got = '0;
    logic [2:0] pp_exp = {ins, ~sc, pv};
    waitn = wt;
    @(negedge clk);
    req_id = id; req_write = w; req_priv = pv; req_sec = sc; req_instr = ins;
    req_addr = a; req_wdata = wd; req_valid = 1;
    while (cyc < 40) begin
      #1;
      if (!exp_allow && psel) seq_ok = 0;
      if (exp_allow) begin
        if (cyc == 0 && psel) seq_ok = 0;
        if (cyc == 1) begin
          if (!(psel && !penable)) seq_ok = 0;
          pp_got = pprot;
          if (paddr != a || pwrite != w || (w && pwdata != wd)) attr_ok = 0;
        end
        if (cyc >= 2 && !(psel && penable)) seq_ok = 0;
        if (cyc >= 2 && pprot != pp_exp) attr_ok = 0;
      end
      if (rsp_done) begin
        done_cyc = cyc; err_got = rsp_err; rd_got = rsp_rdata;
        break;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    @(posedge clk);
    #1 req_valid = 0;
    chk((done_cyc > 0) == exp_allow && done_cyc >= 0, tag, "forward decision",
        32'(done_cyc), exp_allow ? 32'(2 + wt) : 32'd0);
    if (exp_allow) begin
      chk(seq_ok && done_cyc == 2 + wt, "R6", "setup/access sequence latency",
          32'(done_cyc), 32'(2 + wt));
      chk(attr_ok && pp_got == pp_exp, "R7", "pprot and transfer attributes",
          32'(pp_got), 32'(pp_exp));
      chk(err_got == (a[3:0] == 4'hF) && rd_got == {a, ~a}, "R8", "response err/rdata",
          {15'd0, err_got, rd_got}, {15'd0, a[3:0] == 4'hF, a, ~a});
    end else begin
      chk(seq_ok && err_got && rd_got == '0, "R5", "refusal err/rdata/psel",
          {15'd0, err_got, rd_got}, {16'h0001, 16'h0000});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [MW-1:0] masks [5];
    logic [AW-1:0] addrs [4];
    masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'hAAAA;
    masks[3] = 16'h5555; masks[4] = 16'h1E69;
    addrs[0] = 8'h3F; addrs[1] = 8'h40; addrs[2] = 8'h4F; addrs[3] = 8'h50;
    do_reset();
    #1;
    chk(!psel && !penable && !rsp_done, "R1", "idle outputs after reset",
        {29'd0, psel, penable, rsp_done}, 32'd0);
    txn(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h44, 16'h0, 1'b0, "R1", 0);
    txn(3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 8'h4A, 16'h0, 1'b0, "R1", 0);

    for (int mi = 0; mi < 5; mi++) begin
      load_mask(masks[mi], 1'b0);
      for (int id = 0; id < 8; id++)
        for (int w = 0; w < 2; w++)
          for (int pv = 0; pv < 2; pv++)
            for (int ai = 0; ai < 4; ai++) begin
              logic [AW-1:0] a = addrs[ai];
              bit inw = (a >= LO) && (a <= HI);
              bit bitok = masks[mi][id*2 + w];
              bit uw = (w == 1) && (pv == 0);
              bit ea = !inw || (bitok && !uw);
              string tg = !inw ? "R2" : (uw ? "R4" : "R3");
              txn(3'(id), 1'(w), 1'(pv), 1'(id[1] ^ w), 1'(id[0]), a,
                  16'(id * 4099 + ai * 257 + mi), ea, tg, (id + ai) % 3);
            end
    end

    do_reset();
    load_mask(16'h0002, 1'b1);
    load_mask(16'hFFFF, 1'b0);
    txn(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h41, 16'h0, 1'b0, "R9", 0);
    txn(3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h41, 16'hBEEF, 1'b1, "R9", 1);
    txn(3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 8'h4F, 16'h0, 1'b0, "R9", 0);
    load_mask(16'h0000, 1'b0);
    txn(3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h40, 16'h1234, 1'b1, "R9", 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule